// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When an accepted address strobe arrives, it captures the full address. The two lowest bits become the burst start offset, and the upper bits are held for the rest of the burst. Each later clock edge with the active-low advance input asserted moves the offset one step through the burst order. The order is chosen by a static order-select input. Linear order counts up modulo four from the start offset. Interleaved order combines the start offset with the beat number by XOR.

Strobe qualification and chip selection happen upstream. This block sees two pre-qualified strobes, one for each requester, and either one starts a burst. Both outputs are registered. The address for the beat that an edge selects appears right after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset drives the offset and the full burst address to zero at the next edge, whatever the other inputs are.
- R2: At an edge where either strobe input is high, the burst address becomes the value on the address input.
- R3: At an edge that loads an address, the advance input has no effect. This holds whether one strobe or both are high, and the loaded offset is the start offset unchanged.
- R4: With the order select low (linear), each advance edge adds one modulo four to the offset. Starts 00/01/10/11 give 00-01-10-11, 01-10-11-00, 10-11-00-01 and 11-00-01-10.
- R5: With the order select high (interleaved), the offset at beat k is the start offset XOR k. Starts 00/01/10/11 give 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R6: After the fourth beat, one more advance returns the offset to the start offset.
- R7: At an edge with both strobes low and the advance input high, the offset and the full address keep their values.
- R8: The address bits above the two offset bits change only on a load or a reset. A linear step from 11 to 00 does not carry into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe_proc | input | 1 | Qualified address strobe from the first requester, active high |
| strobe_ctrl | input | 1 | Qualified address strobe from the second requester, active high |
| adv_n | input | 1 | Advance to next beat, active low |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_in | input | ADDR_W | Address captured on a load |
| ofs_out | output | 2 | Current beat offset (registered) |
| burst_addr | output | ADDR_W | Held upper bits joined with the current offset (registered) |

## Verification
The hardest case to reach is the wrap that follows a suspended beat. The hidden beat count has to reach three and then roll over while an idle cycle sits in the middle. Only the offset shows the count, so a wrong count looks like a plausible address. The vector table puts a suspend cycle inside an interleaved burst before the wrap. A sweep then runs every start offset in both orders through five beats. The sweep also places a linear start of 11 so that the step to 00 would expose a carry into the upper bits.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned BURST_OFS_W = 2;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;

  function automatic logic [BURST_OFS_W-1:0] beat_step(input logic [BURST_OFS_W-1:0] b);
    return b + 1'b1;
  endfunction
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned OFS_W  = burst_pkg::BURST_OFS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe_proc,
  input  logic                strobe_ctrl,
  input  logic                adv_n,
  input  logic [ADDR_W-1:0]   addr_in,
  output logic [OFS_W-1:0]    base_nx,
  output logic [OFS_W-1:0]    beat_nx,
  output logic [ADDR_W-OFS_W-1:0] upper_nx
);
  localparam int unsigned UP_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] beat_q;
  logic [UP_W-1:0]  upper_q;
  logic             load;

  assign load = strobe_proc | strobe_ctrl;

  // Load takes priority over advance; idle holds state.
  always_comb begin
    base_nx  = base_q;
    beat_nx  = beat_q;
    upper_nx = upper_q;
    if (load) begin
      base_nx  = addr_in[OFS_W-1:0];
      upper_nx = addr_in[ADDR_W-1:OFS_W];
      beat_nx  = '0;
    end else if (!adv_n) begin
      beat_nx  = burst_pkg::beat_step(beat_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      beat_q  <= '0;
      upper_q <= '0;
    end else begin
      base_q  <= base_nx;
      beat_q  <= beat_nx;
      upper_q <= upper_nx;
    end
  end

  // R3: a load restarts the beat count regardless of adv_n
  a_r3_load_restarts: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0));
  // R7: idle cycle freezes the beat count
  a_r7_beat_frozen: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int unsigned OFS_W = burst_pkg::BURST_OFS_W
) (
  input  logic [OFS_W-1:0] base,
  input  logic [OFS_W-1:0] beat,
  input  burst_pkg::order_e order,
  output logic [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] ilv_ofs;

  // Linear: modulo add, carry discarded at the top bit.
  assign lin_ofs = base + beat;

  // Interleaved: bitwise XOR, one gate per bit.
  for (genvar i = 0; i < OFS_W; i++) begin : g_ilv
    assign ilv_ofs[i] = base[i] ^ beat[i];
  end

  assign ofs = (order == burst_pkg::ORD_INTERLEAVED) ? ilv_ofs : lin_ofs;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_proc,
  input  logic              strobe_ctrl,
  input  logic              adv_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [1:0]        ofs_out,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int unsigned OFS_W = burst_pkg::BURST_OFS_W;
  localparam int unsigned UP_W  = ADDR_W - OFS_W;

  logic [OFS_W-1:0] base_nx;
  logic [OFS_W-1:0] beat_nx;
  logic [UP_W-1:0]  upper_nx;
  logic [OFS_W-1:0] ofs_nx;
  logic [OFS_W-1:0] ofs_q;
  logic [UP_W-1:0]  upper_q;
  burst_pkg::order_e order;

  assign order = burst_pkg::order_e'(order_ilv);

  burst_load_ctl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) load_i (
    .clk         (clk),
    .rst         (rst),
    .strobe_proc (strobe_proc),
    .strobe_ctrl (strobe_ctrl),
    .adv_n       (adv_n),
    .addr_in     (addr_in),
    .base_nx     (base_nx),
    .beat_nx     (beat_nx),
    .upper_nx    (upper_nx)
  );

  burst_order_map #(.OFS_W(OFS_W)) map_i (
    .base  (base_nx),
    .beat  (beat_nx),
    .order (order),
    .ofs   (ofs_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q   <= '0;
      upper_q <= '0;
    end else begin
      ofs_q   <= ofs_nx;
      upper_q <= upper_nx;
    end
  end

  assign ofs_out    = ofs_q;
  assign burst_addr = {upper_q, ofs_q};

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (burst_addr == '0));
  // R2: a load presents the captured address
  a_r2_load_addr: assert property (@(posedge clk) disable iff (rst)
    (strobe_proc || strobe_ctrl) |=> (burst_addr == $past(addr_in)));
  // R7: idle cycle holds the address
  a_r7_suspend_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe_proc && !strobe_ctrl && adv_n) |=> $stable(burst_addr));
  // R8: upper bits move only on a load
  a_r8_upper_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe_proc && !strobe_ctrl) |=> $stable(burst_addr[ADDR_W-1:OFS_W]));
  // R4: linear advance is a +1 step
  a_r4_linear_step: assert property (@(posedge clk) disable iff (rst)
    (!strobe_proc && !strobe_ctrl && !adv_n && !order_ilv)
      |=> (ofs_out == 2'($past(ofs_out) + 2'd1)));
  // R5: interleaved advance always changes the offset
  a_r5_ilv_moves: assert property (@(posedge clk) disable iff (rst)
    (!strobe_proc && !strobe_ctrl && !adv_n && order_ilv)
      |=> (ofs_out != $past(ofs_out)));
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int unsigned AW = 17;
  localparam int unsigned NV = 21;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe_proc = 1'b0;
  logic strobe_ctrl = 1'b0;
  logic adv_n = 1'b1;
  logic order_ilv = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [1:0]    ofs_out;
  logic [AW-1:0] burst_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
    .adv_n(adv_n), .order_ilv(order_ilv), .addr_in(addr_in),
    .ofs_out(ofs_out), .burst_addr(burst_addr)
  );

  // {strobe_proc, strobe_ctrl, adv_n, order_ilv, addr_in, expected burst_addr}
  localparam logic [37:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b1,17'h1ABC5,17'h1ABC5},
    {1'b0,1'b0,1'b0,1'b1,17'h00000,17'h1ABC4},
    {1'b0,1'b0,1'b0,1'b1,17'h00000,17'h1ABC7},
    {1'b0,1'b0,1'b1,1'b1,17'h0FFFF,17'h1ABC7},
    {1'b0,1'b0,1'b0,1'b1,17'h00000,17'h1ABC6},
    {1'b0,1'b0,1'b0,1'b1,17'h00000,17'h1ABC5},
    {1'b0,1'b1,1'b0,1'b0,17'h0F0F3,17'h0F0F3},
    {1'b0,1'b0,1'b0,1'b0,17'h00000,17'h0F0F0},
    {1'b0,1'b0,1'b0,1'b0,17'h00000,17'h0F0F1},
    {1'b0,1'b0,1'b0,1'b0,17'h00000,17'h0F0F2},
    {1'b0,1'b0,1'b0,1'b0,17'h00000,17'h0F0F3},
    {1'b1,1'b1,1'b0,1'b1,17'h12342,17'h12342},
    {1'b0,1'b0,1'b0,1'b1,17'h00000,17'h12343},
    {1'b0,1'b0,1'b0,1'b1,17'h00000,17'h12340},
    {1'b0,1'b0,1'b0,1'b1,17'h00000,17'h12341},
    {1'b0,1'b0,1'b0,1'b1,17'h00000,17'h12342},
    {1'b1,1'b0,1'b1,1'b0,17'h00001,17'h00001},
    {1'b0,1'b0,1'b0,1'b0,17'h00000,17'h00002},
    {1'b0,1'b0,1'b0,1'b0,17'h00000,17'h00003},
    {1'b0,1'b0,1'b0,1'b0,17'h00000,17'h00000},
    {1'b0,1'b0,1'b1,1'b0,17'h1FFFF,17'h00000}
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 16:            return "R2 load";
      1, 2, 4, 12, 13, 14: return "R5 interleaved";
      3, 20:            return "R7 suspend";
      5, 10, 15:        return "R6 wrap";
      6:                return "R3 advance ignored on load";
      11:               return "R3 both strobes";
      7, 19:            return "R8 upper held";
      default:          return "R4 linear";
    endcase
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 reset state", burst_addr, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {strobe_proc, strobe_ctrl, adv_n, order_ilv, addr_in} = VEC[i][37:17];
      @(negedge clk);
      chk(vec_req(i), burst_addr, VEC[i][16:0]);
    end

    // Sweep of every start offset in both orders: R4, R5, R6
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        order_ilv   = m[0];
        strobe_proc = 1'b1;
        adv_n       = 1'b1;
        addr_in     = {15'h5555, s[1:0]};
        @(negedge clk);
        strobe_proc = 1'b0;
        adv_n       = 1'b0;
        addr_in     = '0;
        for (int k = 1; k <= 4; k++) begin
          logic [1:0] e;
          e = m[0] ? (s[1:0] ^ k[1:0]) : 2'(s[1:0] + k[1:0]);
          @(negedge clk);
          if (k == 4) chk("R6 sweep wrap", burst_addr, {15'h5555, e});
          else if (m == 1) chk("R5 sweep", burst_addr, {15'h5555, e});
          else chk("R4 sweep", burst_addr, {15'h5555, e});
        end
      end
    end

    // R1: reset wins over a simultaneous load mid-burst
    adv_n = 1'b1;
    strobe_proc = 1'b1;
    addr_in = 17'h1FFFF;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset over load", burst_addr, '0);
    chk("R1 reset offset", {15'h0, ofs_out}, '0);
    rst = 1'b0;
    strobe_proc = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule